// File: doc/BRIEF.md
# Aligned Dual Programmable Clock Divider

This block derives two slower clocks from a single input clock. Bank A produces a clock at one half or one quarter of the input rate. Bank B produces one quarter, one fifth or one sixth of it. Both banks count the same rising input edges from the same starting point, so wherever their periods line up their output edges fall on the same input edge. Several copies released from reset together stay in step.

A run gate, built as a two-state machine clocked on the falling input edge, decides whether the counters advance. Its states are GATE_HOLD and GATE_RUN. It moves GATE_HOLD→GATE_RUN at a falling edge where `hold` is low, GATE_RUN→GATE_HOLD at a falling edge where `hold` is high, and otherwise stays put. Reset forces GATE_HOLD. The counters only move on rising edges, and the gate only changes while the input clock is low. As a result, pausing or resuming never shortens a pulse on either output. The divide selects may only change while the block is held or in reset.

Each bank is a phase counter with a registered output. After reset the phase is zero. The output is high for the first ceil(N/2) advancing edges of every N, then low for the rest.

Top module: `clkdiv_aligned`

## Requirements
- R1: Bank A divides by 2 when `sel_a` is 0 and by 4 when `sel_a` is 1.
- R2: Bank B decodes `sel_b` with bit 1 as MSB: 2'b00 divides by 4, 2'b01 by 6, 2'b10 by 5, and 2'b11 by 5.
- R3: Counting advancing rising edges k = 1, 2, ... since reset, an output with ratio N is high after edge k exactly when (k-1) mod N < ceil(N/2). This gives 50% duty for /2, /4 and /6, and 3 high / 2 low for /5. Outputs change only on rising edges.
- R4: While the gate is in GATE_HOLD, both outputs keep their value across rising edges. After a resume, the sequence continues from the stopped phase, so no pulse is shortened.
- R5: `hold` is sampled only on falling edges. A change made after a falling edge is not seen at the following rising edge, but at the rising edge one cycle later.
- R6: While `rst` is high, both true outputs are low and both complements are high. This takes effect immediately, without waiting for a clock edge, and lasts as long as `rst` stays high.
- R7: Once reset is released while the clock is high, both true outputs rise on the first rising edge that follows a falling edge at which `hold` was low. With `hold` high they stay low.
- R8: Both banks advance on the same edges, so they rise together on edge 1 and on every edge k where k-1 is a multiple of both ratios.
- R9: `qa_n` is always the inverse of `qa`, and `qb_n` is always the inverse of `qb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; counters use rising edges, gate uses falling edges |
| rst | input | 1 | Asynchronous master reset, active high |
| hold | input | 1 | High pauses both dividers, low lets them run |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| qa | output | 1 | Bank A divided clock |
| qa_n | output | 1 | Inverse of `qa` |
| qb | output | 1 | Bank B divided clock |
| qb_n | output | 1 | Inverse of `qb` |

## Verification
The hardest case to reach from the ports is a `hold` change that lands between a falling edge and the next rising edge. Changing `hold` there must not affect the rising edge that follows. The bench moves `hold` two nanoseconds after a falling edge. It then checks that the next rising edge still advances on a pause, or still stays frozen on a resume, and that the edge one cycle later shows the change. The bench also releases reset with `hold` high, and asserts reset in the middle of a high pulse to observe the clearing before any clock edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // Run gate states
    typedef enum logic {
        GATE_HOLD = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_e;

    // Bank B select codes, bit 1 is the MSB
    typedef enum logic [1:0] {
        SELB_DIV4  = 2'b00,
        SELB_DIV6  = 2'b01,
        SELB_DIV5A = 2'b10,
        SELB_DIV5B = 2'b11
    } selb_e;

endpackage

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate
    import clkdiv_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    input  logic hold,
    output logic adv
);

    gate_state_e state, state_nxt;

    // State register on the falling edge, so it only moves while the clock is low
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) state <= GATE_HOLD;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_HOLD: state_nxt = hold ? GATE_HOLD : GATE_RUN;
            GATE_RUN:  state_nxt = hold ? GATE_HOLD : GATE_RUN;
        endcase
    end

    // Output process
    always_comb begin
        adv = (state == GATE_RUN);
    end

    // While reset is high the counters must see no advance
    p_gate_reset_r7: assert property (@(posedge clk_in) rst |-> !adv)
        else $error("gate advancing during reset");

endmodule

// File: rtl/clkdiv_select.sv
`timescale 1ns/1ps
module clkdiv_select
    import clkdiv_pkg::*;
#(
    parameter int unsigned CW       = 3,
    parameter int unsigned DIV_A_LO = 2,
    parameter int unsigned DIV_A_HI = 4,
    parameter int unsigned DIV_B_00 = 4,
    parameter int unsigned DIV_B_01 = 6,
    parameter int unsigned DIV_B_1X = 5
) (
    input  logic          sel_a,
    input  logic [1:0]    sel_b,
    output logic [CW-1:0] ratio_a,
    output logic [CW-1:0] ratio_b
);

    always_comb begin
        ratio_a = sel_a ? CW'(DIV_A_HI) : CW'(DIV_A_LO);
        unique case (selb_e'(sel_b))
            SELB_DIV4:              ratio_b = CW'(DIV_B_00);
            SELB_DIV6:              ratio_b = CW'(DIV_B_01);
            SELB_DIV5A, SELB_DIV5B: ratio_b = CW'(DIV_B_1X);
        endcase
    end

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank #(
    parameter int unsigned CW = 3
) (
    input  logic          clk_in,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] ratio,
    output logic          q
);

    logic [CW-1:0] ph, ph_nxt;
    logic          q_nxt;
    logic [CW:0]   ph_inc;
    logic [CW-1:0] hi_len;

    // Next-phase logic
    always_comb begin
        ph_inc = {1'b0, ph} + {{CW{1'b0}}, 1'b1};
        hi_len = (ratio >> 1) + {{(CW-1){1'b0}}, ratio[0]};
        ph_nxt = ph;
        q_nxt  = q;
        if (adv) begin
            q_nxt  = (ph < hi_len);
            ph_nxt = (ph_inc >= {1'b0, ratio}) ? '0 : ph_inc[CW-1:0];
        end
    end

    // Phase and output registers
    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            ph <= '0;
            q  <= 1'b0;
        end else begin
            ph <= ph_nxt;
            q  <= q_nxt;
        end
    end

    // Phase stays inside the selected ratio (R1, R2)
    p_phase_range_r2: assert property (@(posedge clk_in) disable iff (rst)
        adv |=> (!$stable(ratio) || ph < ratio))
        else $error("phase out of range");

    // Output frozen when the gate does not advance
    p_hold_freeze_r4: assert property (@(posedge clk_in) disable iff (rst)
        !adv |=> $stable(q))
        else $error("output moved while held");

    // Reset clears output and phase
    p_reset_clear_r6: assert property (@(posedge clk_in)
        rst |-> (!q && ph == '0))
        else $error("reset did not clear bank");

endmodule

// File: rtl/clkdiv_aligned.sv
`timescale 1ns/1ps
module clkdiv_aligned #(
    parameter int unsigned DIV_A_LO = 2,
    parameter int unsigned DIV_A_HI = 4,
    parameter int unsigned DIV_B_00 = 4,
    parameter int unsigned DIV_B_01 = 6,
    parameter int unsigned DIV_B_1X = 5
) (
    input  logic       clk_in,
    input  logic       rst,
    input  logic       hold,
    input  logic       sel_a,
    input  logic [1:0] sel_b,
    output logic       qa,
    output logic       qa_n,
    output logic       qb,
    output logic       qb_n
);

    localparam int unsigned MAX_A = (DIV_A_LO > DIV_A_HI) ? DIV_A_LO : DIV_A_HI;
    localparam int unsigned MAX_B0 = (DIV_B_00 > DIV_B_01) ? DIV_B_00 : DIV_B_01;
    localparam int unsigned MAX_B = (MAX_B0 > DIV_B_1X) ? MAX_B0 : DIV_B_1X;
    localparam int unsigned MAXR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW = $clog2(MAXR + 1);
    localparam int unsigned NBANK = 2;

    logic              adv;
    logic [CW-1:0]     ratio [NBANK];
    logic [NBANK-1:0]  qv;

    clkdiv_gate u_gate (
        .clk_in (clk_in),
        .rst    (rst),
        .hold   (hold),
        .adv    (adv)
    );

    clkdiv_select #(
        .CW       (CW),
        .DIV_A_LO (DIV_A_LO),
        .DIV_A_HI (DIV_A_HI),
        .DIV_B_00 (DIV_B_00),
        .DIV_B_01 (DIV_B_01),
        .DIV_B_1X (DIV_B_1X)
    ) u_select (
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .ratio_a (ratio[0]),
        .ratio_b (ratio[1])
    );

    // Banks share one advance strobe, which keeps their edges aligned (R8)
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        clkdiv_bank #(.CW(CW)) u_bank (
            .clk_in (clk_in),
            .rst    (rst),
            .adv    (adv),
            .ratio  (ratio[g]),
            .q      (qv[g])
        );
    end

    assign qa   = qv[0];
    assign qa_n = ~qv[0];
    assign qb   = qv[1];
    assign qb_n = ~qv[1];

endmodule

// File: tb/clkdiv_aligned_bench.sv
`timescale 1ns/1ps
module clkdiv_aligned_bench;

    logic       clk_in = 1'b0;
    logic       rst;
    logic       hold = 1'b0;
    logic       sel_a = 1'b0;
    logic [1:0] sel_b = 2'b00;
    logic       qa, qa_n, qb, qb_n;

    int n_chk = 0;
    int n_bad = 0;
    int kcur  = 0;
    int na    = 2;
    int nb    = 4;

    // fields: sel_a[8], sel_b[7:6], ratio A[5:3], ratio B[2:0] (R1, R2)
    localparam logic [8:0] VEC [0:5] = '{
        {1'b0, 2'b00, 3'd2, 3'd4},
        {1'b1, 2'b01, 3'd4, 3'd6},
        {1'b0, 2'b10, 3'd2, 3'd5},
        {1'b1, 2'b11, 3'd4, 3'd5},
        {1'b1, 2'b00, 3'd4, 3'd4},
        {1'b0, 2'b01, 3'd2, 3'd6}
    };

    clkdiv_aligned u_clkdiv_aligned (
        .clk_in (clk_in),
        .rst    (rst),
        .hold   (hold),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .qa     (qa),
        .qa_n   (qa_n),
        .qb     (qb),
        .qb_n   (qb_n)
    );

    always #5 clk_in = ~clk_in;

    // Expected level after k advancing edges (R3)
    function automatic logic model(int k, int n);
        if (k < 1) return 1'b0;
        return (((k - 1) % n) < ((n + 1) / 2));
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, qa, model(kcur, na));
        chk(req, qb, model(kcur, nb));
        chk("R9", qa_n, ~model(kcur, na));
        chk("R9", qb_n, ~model(kcur, nb));
    endtask

    // Reset, set selects, release with clock high; ends at posedge+2
    task automatic restart(logic sa, logic [1:0] sb, int ra, int rb, logic hold_at_release);
        @(posedge clk_in); #2;
        rst = 1'b1; sel_a = sa; sel_b = sb; hold = hold_at_release;
        na = ra; nb = rb; kcur = 0;
        repeat (2) @(posedge clk_in);
        #2;
        check_all("R6");
        rst = 1'b0;
    endtask

    task automatic run_edges(int cnt, string req);
        for (int i = 0; i < cnt; i++) begin
            @(posedge clk_in); #1;
            kcur++;
            check_all(req);
        end
    endtask

    task automatic frozen_edges(int cnt, string req);
        for (int i = 0; i < cnt; i++) begin
            @(posedge clk_in); #1;
            check_all(req);
        end
    endtask

    initial begin
        rst = 1'b0;
        #1 rst = 1'b1;

        // Table walk: ratios, waveform shape, alignment (R1 R2 R3 R7 R8)
        for (int v = 0; v < 6; v++) begin
            restart(VEC[v][8], VEC[v][7:6], int'(VEC[v][5:3]), int'(VEC[v][2:0]), 1'b0);
            run_edges(30, "R1/R2/R3/R8");
        end

        // Hold freezes, resume continues the phase (R4)
        restart(1'b1, 2'b10, 4, 5, 1'b0);
        run_edges(3, "R3");
        #1 hold = 1'b1;
        frozen_edges(6, "R4");
        #1 hold = 1'b0;
        run_edges(12, "R4");

        // Hold changed after a falling edge (R5)
        #6 hold = 1'b1;
        run_edges(1, "R5");
        frozen_edges(3, "R5");
        #6 hold = 1'b0;
        frozen_edges(1, "R5");
        run_edges(8, "R5");

        // Asynchronous reset in the middle of a high pulse (R6)
        restart(1'b1, 2'b00, 4, 4, 1'b0);
        run_edges(2, "R8");
        #2 rst = 1'b1;
        kcur = 0;
        #1 check_all("R6");
        frozen_edges(4, "R6");
        #1 rst = 1'b0;
        run_edges(8, "R7");

        // Release with hold high, outputs stay low until hold drops (R7)
        restart(1'b0, 2'b01, 2, 6, 1'b1);
        frozen_edges(3, "R7");
        #1 hold = 1'b0;
        run_edges(14, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule